// File: doc/BRIEF.md
# Clarke-Park Vector Rotator

This block turns sampled phase quantities into an orthogonal pair and rotates that pair by a digital angle. It is fully synchronous and uses fixed-point arithmetic. A two-bit mode input picks the input format. In the quadrature format a cosine and a sine sample are used directly. In the three-wire format three 120-degree phases pass through a 3-to-2 transform. In the two-wire format only the second and third phases are given, and the first phase is rebuilt from them.

The rotation angle is a 12-bit unsigned code, and 4096 codes make one full turn. The angle is captured on the rising edge of a strobe. The falling edge of the strobe starts an iterative CORDIC that finds the sine and cosine of the angle. A busy flag covers the whole computation. Both factors are loaded into the multiplier stage in one cycle, so the rotated outputs never mix an old sine with a new cosine.

The block presents three sets of outputs:
- the unrotated pair;
- the rotated pair;
- a three-phase set derived from the rotated pair by a 2-to-3 transform.

All values are signed 16-bit Q1.15 and saturate at the rails.

Top module: `vrot_top`

## Requirements
- R1: After reset, busy and stb_reject are low, every data output is zero, and the rotation factors are cos = 32767 and sin = 0, so the rotated pair follows the unrotated pair.
- R2: With mode 00 (quadrature), alpha_o equals phase_u and beta_o equals quad_in, one clock after they are sampled.
- R3: With mode 01, or the spare code 11 treated the same way, alpha_o equals phase_u and beta_o equals floor((phase_w − phase_v) · 18919 / 2^15). 18919 is 1/√3 in Q1.15.
- R4: With mode 10, alpha_o equals −(phase_v + phase_w), beta_o is formed as in R3, and phase_u has no effect.
- R5: Any unrotated, rotated or three-phase result outside −32768..32767 is clamped to the nearer limit.
- R6: angle is captured on a rising edge of ang_stb, and code k means k/4096 of a turn. A falling edge of ang_stb after an accepted rising edge starts a conversion, and busy is high from the next cycle.
- R7: busy stays high for exactly 17 clock cycles per conversion.
- R8: The sine and cosine factors both change in the cycle busy falls. While busy is high, rot_d and rot_q keep the previous rotation.
- R9: rot_d ≈ α·cos φ − β·sin φ and rot_q ≈ α·sin φ + β·cos φ, within 16 LSB. They are valid two cycles after the factors and the unrotated pair settle.
- R10: rot_u = rot_d, rot_v ≈ −rot_d/2 − rot_q·√3/2 and rot_w ≈ −rot_d/2 + rot_q·√3/2, within 24 LSB. They lag the rotated pair by one cycle.
- R11: A rising edge of ang_stb seen while busy is high does three things:
  - the angle is not captured;
  - the matching falling edge starts nothing;
  - stb_reject goes high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Input format select (00 quadrature, 01/11 three-wire, 10 two-wire) |
| phase_u | input | 16 | First phase sample, or cosine in quadrature mode |
| phase_v | input | 16 | Second phase sample |
| phase_w | input | 16 | Third phase sample |
| quad_in | input | 16 | Sine sample in quadrature mode |
| angle | input | 12 | Rotation angle code, full turn = 4096 |
| ang_stb | input | 1 | Angle strobe: rise captures, fall starts |
| busy | output | 1 | Conversion in progress |
| stb_reject | output | 1 | One-cycle pulse for a strobe ignored while busy |
| alpha_o | output | 16 | Unrotated cosine component |
| beta_o | output | 16 | Unrotated sine component |
| rot_d | output | 16 | Rotated cosine component |
| rot_q | output | 16 | Rotated sine component |
| rot_u | output | 16 | Rotated phase at 0° |
| rot_v | output | 16 | Rotated phase at +120° |
| rot_w | output | 16 | Rotated phase at +240° |

## Verification
The end of a conversion and a new strobe edge can land in the same cycle. In that cycle busy falls and the factors load, while a rising edge of ang_stb arrives. The bench counts cycles from the start of a conversion and raises the strobe so that its rising edge is sampled on the exact clock where busy clears. It then expects three things:
- a one-cycle stb_reject;
- no new busy period after the strobe falls;
- rotated outputs that still match the earlier angle and not the rejected one.

A strobe raised one cycle later is accepted as normal.

// File: rtl/vrot_pkg.sv
package vrot_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'b00,
    MODE_TRI3 = 2'b01,
    MODE_TRI2 = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;

  localparam logic signed [47:0] SAT_HI = (48'sd1 <<< (DW - 1)) - 48'sd1;
  localparam logic signed [47:0] SAT_LO = -(48'sd1 <<< (DW - 1));
  localparam logic signed [47:0] INV_SQRT3 = 48'sd18919;
  localparam logic signed [47:0] HALF_SQRT3 = 48'sd28378;

  function automatic logic signed [DW-1:0] sat(input logic signed [47:0] v);
    if (v > SAT_HI) return SAT_HI[DW-1:0];
    else if (v < SAT_LO) return SAT_LO[DW-1:0];
    else return $signed(v[DW-1:0]);
  endfunction
endpackage

// File: rtl/vrot_clarke.sv
module vrot_clarke
  import vrot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic signed [DW-1:0] phase_u,
  input  logic signed [DW-1:0] phase_v,
  input  logic signed [DW-1:0] phase_w,
  input  logic signed [DW-1:0] quad_in,
  output logic signed [DW-1:0] alpha_o,
  output logic signed [DW-1:0] beta_o
);
  mode_e m;
  logic signed [47:0] diff_vw, beta_tri, a_sel, b_sel;

  always_comb begin
    m        = mode_e'(mode);
    diff_vw  = 48'(phase_w) - 48'(phase_v);
    beta_tri = (diff_vw * INV_SQRT3) >>> 15;
    case (m)
      MODE_QUAD: begin a_sel = 48'(phase_u); b_sel = 48'(quad_in); end
      MODE_TRI2: begin a_sel = -(48'(phase_v) + 48'(phase_w)); b_sel = beta_tri; end
      default:   begin a_sel = 48'(phase_u); b_sel = beta_tri; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alpha_o <= '0;
      beta_o  <= '0;
    end else begin
      alpha_o <= sat(a_sel);
      beta_o  <= sat(b_sel);
    end
  end

  // R2: quadrature mode passes the cosine sample straight through
  assert_quad_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (alpha_o == $past(phase_u)));
endmodule

// File: rtl/vrot_cordic.sv
module vrot_cordic
  import vrot_pkg::*;
#(
  parameter int AW   = 12,
  parameter int ITER = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [AW-1:0]        angle,
  output logic                 done,
  output logic signed [DW-1:0] cos_o,
  output logic signed [DW-1:0] sin_o
);
  localparam int XW = DW + 3;
  localparam int ZW = 22;
  localparam int ZS = 20 - AW;
  localparam int CW = $clog2(ITER + 1);
  localparam longint KVAL = ((64'sd1 <<< (DW - 1)) * 64'sd607253) / 64'sd1000000;

  logic signed [XW-1:0] x, y;
  logic signed [ZW-1:0] z;
  logic [1:0]           quad;
  logic [CW-1:0]        it;
  logic                 run;

  // arctan(2^-i) with a full turn equal to 2^20
  function automatic logic signed [ZW-1:0] atan_turn(input int i);
    case (i)
      0: return 22'sd131072;  1: return 22'sd77376;  2: return 22'sd40884;
      3: return 22'sd20753;   4: return 22'sd10417;  5: return 22'sd5213;
      6: return 22'sd2607;    7: return 22'sd1304;   8: return 22'sd652;
      9: return 22'sd326;    10: return 22'sd163;   11: return 22'sd81;
      12: return 22'sd41;    13: return 22'sd20;    14: return 22'sd10;
      15: return 22'sd5;
      default: return 22'sd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b0;
      it   <= '0;
      x    <= '0;
      y    <= '0;
      z    <= '0;
      quad <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        it   <= '0;
        x    <= XW'(KVAL);
        y    <= '0;
        z    <= {{(ZW - AW + 2){1'b0}}, angle[AW-3:0]} << ZS;
        quad <= angle[AW-1:AW-2];
      end else if (run) begin
        if (z[ZW-1]) begin
          x <= x + (y >>> it);
          y <= y - (x >>> it);
          z <= z + atan_turn(int'(it));
        end else begin
          x <= x - (y >>> it);
          y <= y + (x >>> it);
          z <= z - atan_turn(int'(it));
        end
        it <= it + 1'b1;
        if (it == CW'(ITER - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // quadrant restore from the folded 0..90 degree result
  always_comb begin
    case (quad)
      2'd0: begin cos_o = sat(48'(x));  sin_o = sat(48'(y));  end
      2'd1: begin cos_o = sat(-48'(y)); sin_o = sat(48'(x));  end
      2'd2: begin cos_o = sat(-48'(x)); sin_o = sat(-48'(y)); end
      default: begin cos_o = sat(48'(y)); sin_o = sat(-48'(x)); end
    endcase
  end

  // R7: a result appears only at the end of a running iteration
  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run));
endmodule

// File: rtl/vrot_park.sv
module vrot_park
  import vrot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] alpha,
  input  logic signed [DW-1:0] beta,
  input  logic signed [DW-1:0] fcos,
  input  logic signed [DW-1:0] fsin,
  output logic signed [DW-1:0] rot_d,
  output logic signed [DW-1:0] rot_q,
  output logic signed [DW-1:0] rot_u,
  output logic signed [DW-1:0] rot_v,
  output logic signed [DW-1:0] rot_w
);
  logic signed [47:0] md, mq, half_d, q_term;

  always_comb begin
    md     = (48'(alpha) * 48'(fcos) - 48'(beta) * 48'(fsin)) >>> 15;
    mq     = (48'(alpha) * 48'(fsin) + 48'(beta) * 48'(fcos)) >>> 15;
    half_d = 48'(rot_d) >>> 1;
    q_term = (48'(rot_q) * HALF_SQRT3) >>> 15;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_d <= '0;
      rot_q <= '0;
      rot_u <= '0;
      rot_v <= '0;
      rot_w <= '0;
    end else begin
      rot_d <= sat(md);
      rot_q <= sat(mq);
      rot_u <= rot_d;
      rot_v <= sat(-half_d - q_term);
      rot_w <= sat(-half_d + q_term);
    end
  end

  // R10: the zero-degree phase tracks the rotated cosine one cycle later
  assert_u_follows_d_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rot_u == $past(rot_d)));
endmodule

// File: rtl/vrot_top.sv
module vrot_top
  import vrot_pkg::*;
#(
  parameter int AW   = 12,
  parameter int ITER = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic signed [15:0]   phase_u,
  input  logic signed [15:0]   phase_v,
  input  logic signed [15:0]   phase_w,
  input  logic signed [15:0]   quad_in,
  input  logic [AW-1:0]        angle,
  input  logic                 ang_stb,
  output logic                 busy,
  output logic                 stb_reject,
  output logic signed [15:0]   alpha_o,
  output logic signed [15:0]   beta_o,
  output logic signed [15:0]   rot_d,
  output logic signed [15:0]   rot_q,
  output logic signed [15:0]   rot_u,
  output logic signed [15:0]   rot_v,
  output logic signed [15:0]   rot_w
);
  localparam int BLW = $clog2(ITER + 3);
  localparam logic signed [DW-1:0] ONE_Q = (DW)'((64'sd1 <<< (DW - 1)) - 64'sd1);

  logic                 stb_q, armed, stb_rise, stb_fall, conv_start;
  logic [AW-1:0]        ang_lat;
  logic                 c_done;
  logic signed [DW-1:0] c_cos, c_sin, f_cos, f_sin;
  logic [BLW-1:0]       busy_len;

  assign stb_rise   = ang_stb & ~stb_q;
  assign stb_fall   = ~ang_stb & stb_q;
  assign conv_start = stb_fall & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q      <= 1'b0;
      armed      <= 1'b0;
      busy       <= 1'b0;
      stb_reject <= 1'b0;
      ang_lat    <= '0;
      f_cos      <= ONE_Q;
      f_sin      <= '0;
    end else begin
      stb_q      <= ang_stb;
      stb_reject <= 1'b0;
      if (stb_rise) begin
        if (busy) stb_reject <= 1'b1;
        else begin
          ang_lat <= angle;
          armed   <= 1'b1;
        end
      end
      if (conv_start) begin
        armed <= 1'b0;
        busy  <= 1'b1;
      end
      if (c_done) begin
        busy  <= 1'b0;
        f_cos <= c_cos;
        f_sin <= c_sin;
      end
    end
  end

  vrot_clarke u_clarke (
    .clk(clk), .rst(rst), .mode(mode),
    .phase_u(phase_u), .phase_v(phase_v), .phase_w(phase_w), .quad_in(quad_in),
    .alpha_o(alpha_o), .beta_o(beta_o)
  );

  vrot_cordic #(.AW(AW), .ITER(ITER)) u_cordic (
    .clk(clk), .rst(rst), .start(conv_start), .angle(ang_lat),
    .done(c_done), .cos_o(c_cos), .sin_o(c_sin)
  );

  vrot_park u_park (
    .clk(clk), .rst(rst), .alpha(alpha_o), .beta(beta_o),
    .fcos(f_cos), .fsin(f_sin),
    .rot_d(rot_d), .rot_q(rot_q), .rot_u(rot_u), .rot_v(rot_v), .rot_w(rot_w)
  );

  // busy period length monitor
  always_ff @(posedge clk) begin
    if (rst) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  // R6: busy rises only after a strobe falling edge
  assert_busy_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stb_q && !ang_stb));

  // R7: each busy period lasts ITER+1 cycles
  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == BLW'(ITER + 1)));

  // R8: factors move only together with the end of busy
  assert_factors_together_R8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(f_cos) || !$stable(f_sin)) |-> $fell(busy));

  // R11: a reject pulse only follows a busy cycle and lasts one cycle
  assert_reject_busy_R11: assert property (@(posedge clk) disable iff (rst)
    stb_reject |-> ($past(busy) && !$past(stb_reject)));
endmodule

// File: tb/vrot_top_tb.sv
`timescale 1ns/1ps
module vrot_top_tb;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] mode;
  logic signed [15:0] pu, pv, pw, pq;
  logic [11:0] ang;
  logic stb;
  logic busy, rej;
  logic signed [15:0] al, be, rd, rq, ru, rv, rw;

  int n_chk = 0;
  int n_err = 0;
  int cur_ang = 0;

  always #4 clk = ~clk;

  vrot_top u_dut (
    .clk(clk), .rst(rst), .mode(mode),
    .phase_u(pu), .phase_v(pv), .phase_w(pw), .quad_in(pq),
    .angle(ang), .ang_stb(stb), .busy(busy), .stb_reject(rej),
    .alpha_o(al), .beta_o(be), .rot_d(rd), .rot_q(rq),
    .rot_u(ru), .rot_v(rv), .rot_w(rw)
  );

  function automatic longint clampv(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint exp_alpha();
    if (mode == 2'b00) return longint'(pu);
    if (mode == 2'b10) return clampv(-(longint'(pv) + longint'(pw)));
    return longint'(pu);
  endfunction

  function automatic longint exp_beta();
    longint t;
    if (mode == 2'b00) return longint'(pq);
    t = (longint'(pw) - longint'(pv)) * 18919;
    return clampv(t >>> 15);
  endfunction

  task automatic chk(input string tag, input longint act, input real expv, input real tol);
    real d;
    n_chk++;
    d = $itor(act) - expv;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0f", tag, act, expv);
    end
  endtask

  task automatic set_in(input logic [1:0] m, input int u, input int v, input int w, input int q);
    @(negedge clk);
    mode = m; pu = 16'(u); pv = 16'(v); pw = 16'(w); pq = 16'(q);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_unrot(input string tag);
    chk(tag, longint'(al), $itor(exp_alpha()), 0.0);
    chk(tag, longint'(be), $itor(exp_beta()), 0.0);
  endtask

  task automatic check_rot(input string tag);
    real phi, a, b, d, q;
    phi = 6.283185307179586 * $itor(cur_ang) / 4096.0;
    a = $itor(exp_alpha());
    b = $itor(exp_beta());
    d = a * $cos(phi) - b * $sin(phi);
    q = a * $sin(phi) + b * $cos(phi);
    chk({tag, " R9 d"}, longint'(rd), d, 16.0);
    chk({tag, " R9 q"}, longint'(rq), q, 16.0);
    chk({tag, " R10 u"}, longint'(ru), d, 24.0);
    chk({tag, " R10 v"}, longint'(rv), -0.5 * d - 0.8660254 * q, 24.0);
    chk({tag, " R10 w"}, longint'(rw), -0.5 * d + 0.8660254 * q, 24.0);
  endtask

  task automatic convert(input int a);
    int cnt;
    logic signed [15:0] bd, bq, ld, lq;
    @(negedge clk); ang = 12'(a); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    bd = rd; bq = rq; ld = rd; lq = rq;
    @(negedge clk);
    chk("R6 busy after fall", longint'(busy), 1.0, 0.0);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++; ld = rd; lq = rq;
      @(negedge clk);
    end
    chk("R7 busy length", longint'(cnt), 17.0, 0.0);
    chk("R8 hold d during busy", longint'(ld), $itor(bd), 0.0);
    chk("R8 hold q during busy", longint'(lq), $itor(bq), 0.0);
    cur_ang = a;
    repeat (3) @(negedge clk);
  endtask

  task automatic balanced(input logic [1:0] m, input int amp, input int th);
    real t;
    t = 6.283185307179586 * $itor(th) / 4096.0;
    set_in(m, $rtoi($itor(amp) * $cos(t)),
              $rtoi($itor(amp) * $cos(t + 2.0943951)),
              $rtoi($itor(amp) * $cos(t + 4.1887902)),
              $rtoi($itor(amp) * $sin(t)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed;
    int a3;
    rst = 1'b1; mode = 2'b00; pu = 0; pv = 0; pw = 0; pq = 0; ang = 0; stb = 1'b0;
    seed = $urandom(32'h5eed);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", longint'(busy), 0.0, 0.0);
    chk("R1 reject", longint'(rej), 0.0, 0.0);
    chk("R1 rot_d", longint'(rd), 0.0, 0.0);
    chk("R1 rot_w", longint'(rw), 0.0, 0.0);
    chk("R1 alpha", longint'(al), 0.0, 0.0);
    // R1 identity rotation before any strobe, R2 quadrature bypass
    set_in(2'b00, 12000, 0, 0, -7000);
    check_unrot("R2 quad");
    check_rot("R1 identity");

    // directed angles in three-wire mode (R3, R6, R9, R10)
    balanced(2'b01, 15000, 300);
    check_unrot("R3 tri3");
    for (int k = 0; k < 6; k++) begin
      int at;
      case (k)
        0: at = 1024; 1: at = 2048; 2: at = 3072;
        3: at = 4095; 4: at = 512;  default: at = 0;
      endcase
      convert(at);
      check_rot("R6 directed");
    end
    // spare code behaves as three-wire (R3)
    balanced(2'b11, 9000, 1500);
    check_unrot("R3 spare code");
    check_rot("R3 spare code");
    // two-wire mode ignores phase_u (R4)
    set_in(2'b10, 5000, 6000, -9000, 0);
    check_unrot("R4 tri2");
    set_in(2'b10, -20000, 6000, -9000, 1234);
    check_unrot("R4 phase_u ignored");
    check_rot("R4 tri2");

    // saturation (R5)
    set_in(2'b01, 0, -32768, 32767, 0);
    check_unrot("R5 beta clamp");
    set_in(2'b10, 0, -32768, -32768, 0);
    check_unrot("R5 alpha clamp");
    set_in(2'b00, 32767, 0, 0, 32767);
    convert(512);
    chk("R5 rot_q clamp", longint'(rq), 32767.0, 0.0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      int m, amp, th, a;
      m = int'($urandom % 4);
      amp = 2000 + int'($urandom % 18000);
      th = int'($urandom % 4096);
      a = int'($urandom % 4096);
      balanced(2'(m), amp, th);
      if (m == 2) begin
        @(negedge clk); pu = 16'($urandom);
        repeat (3) @(negedge clk);
      end
      check_unrot("R2 R3 R4 random");
      convert(a);
      check_rot("random");
    end

    // R11: strobe rise on the very cycle busy clears
    balanced(2'b01, 14000, 700);
    convert(1000);
    @(negedge clk); ang = 12'd2000; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    repeat (17) @(negedge clk);
    chk("R11 busy still high", longint'(busy), 1.0, 0.0);
    a3 = 3300;
    ang = 12'(a3); stb = 1'b1;
    @(negedge clk);
    chk("R11 reject pulse", longint'(rej), 1.0, 0.0);
    chk("R11 busy cleared", longint'(busy), 0.0, 0.0);
    stb = 1'b0;
    @(negedge clk);
    chk("R11 reject one cycle", longint'(rej), 0.0, 0.0);
    chk("R11 no start", longint'(busy), 0.0, 0.0);
    repeat (3) @(negedge clk);
    chk("R11 still idle", longint'(busy), 0.0, 0.0);
    cur_ang = 2000;
    check_rot("R11 old angle kept");
    // next strobe is accepted normally
    convert(a3);
    check_rot("R11 later accepted");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule